// File: doc/BRIEF.md
# System Control Register Bank

This block is the register file of a processor's system control coprocessor. The core reaches it through one move port. Each access carries a primary register number, a secondary register number, two opcode fields, a direction flag, a data word and a flag that says the core is in user mode. The bank answers in the same cycle. It returns an accepted flag and, for reads, the selected word. A write takes effect on the next clock edge.

The bank holds three fixed identification words and a control word. It also holds the two cache configuration words, a write-buffer word, the two permission words and a parameterised set of protection-region words. It holds the two cache lockdown words and the two tightly-coupled-memory region words. Several of these drive outputs that the rest of the core uses:
- the endianness, vector-base and load-to-PC interworking controls;
- the permission and region words;
- the data TCM base;
- a wait-for-interrupt request, raised by one write encoding and cleared by an interrupt.

Top module: `sysctl_regbank`

## Requirements
- R1: An access with `acc_user` high is always rejected. It returns `acc_rdata` = 0 and changes no register. This includes the wait-for-interrupt encoding.
- R2: With primary=0, secondary=0 and opcode1=0, reads are accepted for every opcode2. Opcode2=1 returns 0x0F0D2112 and opcode2=2 returns 0x00140140. Every other opcode2 returns 0x41049460. Every write with primary=0 is rejected.
- R3: The control word is at primary=1, with all other fields 0, and resets to 0. `endian_big_o` follows bit 7 and `vec_high_o` follows bit 13. `pcload_interwork_o` is the inverse of bit 15.
- R4: Read/write words, all resetting to 0:
  - primary=2, secondary=0, opcode1=0: opcode2 0 is the data cache configuration and opcode2 1 the instruction cache configuration.
  - primary=3 with all other fields 0: the write-buffer word.
  - primary=9, secondary=0, opcode1=0: opcode2 0 is the data lockdown word and opcode2 1 the instruction lockdown word.
- R5: Primary=5, secondary=0, opcode1=0: opcode2 2 is the data permission word and opcode2 3 the instruction permission word. Both reset to 0x22222222. A write shows on `perm_data_o`/`perm_inst_o` after the clock edge that takes it, not before.
- R6: Primary=6 with both opcodes 0 selects region word k = secondary, for k < NREGION. Each region word resets to 0 and shows on `region_words_o[32k+31:32k]` after the write edge. Secondary >= NREGION is rejected.
- R7: Primary=9, secondary=1, opcode1=0: opcode2 0 is the data TCM word (reset 0x0080000A) and opcode2 1 the instruction TCM word (reset 0x0000000C). `dtcm_base_o` is the data TCM word with bits 5:0 cleared. `itcm_base_o` is always 0, and the instruction TCM word still reads back what was written.
- R8: A write with primary=7, secondary=0, opcode1=0 and opcode2=4 is accepted. `wfi_req_o` rises after that edge and stays high until a clock edge with `irq_i` high, after which it is low. A read of that encoding is rejected.
- R9: Any other field combination is rejected. It returns `acc_rdata` = 0 and changes no register.
- R10: With `acc_valid` low, `acc_ok` is low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_user | input | 1 | Core is in user mode |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op1 | input | 3 | Opcode1 field |
| acc_op2 | input | 3 | Opcode2 field |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, 0 unless an accepted read |
| acc_ok | output | 1 | Access decoded and accepted |
| irq_i | input | 1 | Interrupt seen, ends a wait |
| endian_big_o | output | 1 | Big-endian mode select |
| vec_high_o | output | 1 | High exception vector base select |
| pcload_interwork_o | output | 1 | Loads to PC may change instruction state |
| perm_data_o | output | 32 | Data permission word |
| perm_inst_o | output | 32 | Instruction permission word |
| region_words_o | output | NREGION*32 | Protection region words, region 0 in the low bits |
| dtcm_base_o | output | 32 | Data TCM base |
| itcm_base_o | output | 32 | Instruction TCM base, always 0 |
| wfi_req_o | output | 1 | Wait-for-interrupt request |

## Verification
The hardest behaviour to show from the ports is that none of the thousands of undecoded field combinations writes anything. A rejected write leaves no mark unless every register is later read back.

The bench drives each of the 16384 coordinate combinations three times:
- as a privileged read;
- as a user-mode write of all ones;
- as a privileged write of all ones, for each combination a bench-side decode model calls illegal.

After the write passes, it sweeps all reads again and checks every exported output against reset values. It then writes distinct patterns to every writable word and sweeps once more.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;

    localparam int XLEN = 32;

    localparam logic [XLEN-1:0] ID_WORD    = 32'h4104_9460;
    localparam logic [XLEN-1:0] CTYPE_WORD = 32'h0F0D_2112;
    localparam logic [XLEN-1:0] TCMSZ_WORD = 32'h0014_0140;
    localparam logic [XLEN-1:0] PERM_RST   = 32'h2222_2222;
    localparam logic [XLEN-1:0] DTCM_RST   = 32'h0080_000A;
    localparam logic [XLEN-1:0] ITCM_RST   = 32'h0000_000C;
    localparam int              TCM_LOW_BITS = 6;

    localparam int BIT_BIG_ENDIAN = 7;
    localparam int BIT_HIGH_VEC   = 13;
    localparam int BIT_NO_INTERWK = 15;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_ID,
        SEL_CTYPE,
        SEL_TCMSZ,
        SEL_CTRL,
        SEL_DCCFG,
        SEL_ICCFG,
        SEL_WBUF,
        SEL_DPERM,
        SEL_IPERM,
        SEL_REGION,
        SEL_DLOCK,
        SEL_ILOCK,
        SEL_DTCM,
        SEL_ITCM,
        SEL_WAIT
    } sel_e;

    typedef struct packed {
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] op1;
        logic [2:0] op2;
    } cpsel_t;

    typedef struct packed {
        sel_e       sel;
        logic [3:0] idx;
    } hit_t;

    function automatic logic sel_read_only(sel_e s);
        return (s == SEL_ID) || (s == SEL_CTYPE) || (s == SEL_TCMSZ);
    endfunction

    function automatic logic sel_write_only(sel_e s);
        return s == SEL_WAIT;
    endfunction

    function automatic logic [XLEN-1:0] tcm_base(logic [XLEN-1:0] w);
        return {w[XLEN-1:TCM_LOW_BITS], {TCM_LOW_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
`timescale 1ns/1ps
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int NREGION = 8
) (
    input  cpsel_t a,
    output hit_t   hit
);

    always_comb begin
        hit.sel = SEL_NONE;
        hit.idx = '0;
        unique case (a.crn)
            4'd0: if (a.crm == 4'd0 && a.op1 == 3'd0) begin
                case (a.op2)
                    3'd1:    hit.sel = SEL_CTYPE;
                    3'd2:    hit.sel = SEL_TCMSZ;
                    default: hit.sel = SEL_ID;
                endcase
            end
            4'd1: if (a.crm == 4'd0 && a.op1 == 3'd0 && a.op2 == 3'd0)
                hit.sel = SEL_CTRL;
            4'd2: if (a.crm == 4'd0 && a.op1 == 3'd0) begin
                if (a.op2 == 3'd0)      hit.sel = SEL_DCCFG;
                else if (a.op2 == 3'd1) hit.sel = SEL_ICCFG;
            end
            4'd3: if (a.crm == 4'd0 && a.op1 == 3'd0 && a.op2 == 3'd0)
                hit.sel = SEL_WBUF;
            4'd5: if (a.crm == 4'd0 && a.op1 == 3'd0) begin
                if (a.op2 == 3'd2)      hit.sel = SEL_DPERM;
                else if (a.op2 == 3'd3) hit.sel = SEL_IPERM;
            end
            4'd6: if (a.op1 == 3'd0 && a.op2 == 3'd0 && int'(a.crm) < NREGION) begin
                hit.sel = SEL_REGION;
                hit.idx = a.crm;
            end
            4'd7: if (a.crm == 4'd0 && a.op1 == 3'd0 && a.op2 == 3'd4)
                hit.sel = SEL_WAIT;
            4'd9: if (a.op1 == 3'd0) begin
                if (a.crm == 4'd0) begin
                    if (a.op2 == 3'd0)      hit.sel = SEL_DLOCK;
                    else if (a.op2 == 3'd1) hit.sel = SEL_ILOCK;
                end else if (a.crm == 4'd1) begin
                    if (a.op2 == 3'd0)      hit.sel = SEL_DTCM;
                    else if (a.op2 == 3'd1) hit.sel = SEL_ITCM;
                end
            end
            default: hit.sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sysctl_regs.sv
`timescale 1ns/1ps
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int NREGION = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  hit_t                    hit,
    input  logic [XLEN-1:0]         wdata,
    output logic [XLEN-1:0]         rdata,
    output logic [XLEN-1:0]         ctrl_o,
    output logic [XLEN-1:0]         perm_d_o,
    output logic [XLEN-1:0]         perm_i_o,
    output logic [XLEN-1:0]         dtcm_o,
    output logic [NREGION*XLEN-1:0] region_o
);

    logic [XLEN-1:0] ctrl_q, dcc_q, icc_q, wb_q, dp_q, ip_q;
    logic [XLEN-1:0] dl_q, il_q, dt_q, it_q;
    logic [XLEN-1:0] rgn_q [NREGION];
    logic [XLEN-1:0] rgn_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dcc_q  <= '0;
            icc_q  <= '0;
            wb_q   <= '0;
            dp_q   <= PERM_RST;
            ip_q   <= PERM_RST;
            dl_q   <= '0;
            il_q   <= '0;
            dt_q   <= DTCM_RST;
            it_q   <= ITCM_RST;
        end else if (wr_en) begin
            case (hit.sel)
                SEL_CTRL:  ctrl_q <= wdata;
                SEL_DCCFG: dcc_q  <= wdata;
                SEL_ICCFG: icc_q  <= wdata;
                SEL_WBUF:  wb_q   <= wdata;
                SEL_DPERM: dp_q   <= wdata;
                SEL_IPERM: ip_q   <= wdata;
                SEL_DLOCK: dl_q   <= wdata;
                SEL_ILOCK: il_q   <= wdata;
                SEL_DTCM:  dt_q   <= wdata;
                SEL_ITCM:  it_q   <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NREGION; g++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst)
                rgn_q[g] <= '0;
            else if (wr_en && hit.sel == SEL_REGION && hit.idx == 4'(g))
                rgn_q[g] <= wdata;
        end
        assign region_o[g*XLEN +: XLEN] = rgn_q[g];
    end

    always_comb begin
        rgn_rd = '0;
        for (int k = 0; k < NREGION; k++)
            if (hit.idx == 4'(k)) rgn_rd = rgn_q[k];
    end

    always_comb begin
        case (hit.sel)
            SEL_ID:     rdata = ID_WORD;
            SEL_CTYPE:  rdata = CTYPE_WORD;
            SEL_TCMSZ:  rdata = TCMSZ_WORD;
            SEL_CTRL:   rdata = ctrl_q;
            SEL_DCCFG:  rdata = dcc_q;
            SEL_ICCFG:  rdata = icc_q;
            SEL_WBUF:   rdata = wb_q;
            SEL_DPERM:  rdata = dp_q;
            SEL_IPERM:  rdata = ip_q;
            SEL_REGION: rdata = rgn_rd;
            SEL_DLOCK:  rdata = dl_q;
            SEL_ILOCK:  rdata = il_q;
            SEL_DTCM:   rdata = dt_q;
            SEL_ITCM:   rdata = it_q;
            default:    rdata = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign perm_d_o = dp_q;
    assign perm_i_o = ip_q;
    assign dtcm_o   = dt_q;

    // R9: without a write strobe the stored words hold
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q) && $stable(dp_q) && $stable(ip_q) && $stable(dt_q) && $stable(it_q));

    // R5: permission word takes the written value at the next edge
    p_perm_next_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit.sel == SEL_DPERM) |=> perm_d_o == $past(wdata));

endmodule

// File: rtl/sysctl_wfi.sv
`timescale 1ns/1ps
module sysctl_wfi (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic irq_i,
    output logic req_o
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)        req_q <= 1'b0;
        else if (set_i) req_q <= 1'b1;
        else if (irq_i) req_q <= 1'b0;
    end

    assign req_o = req_q;

    p_wfi_set_r8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> req_o);

    p_wfi_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (req_o && !irq_i) |=> req_o);

    p_wfi_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (req_o && irq_i && !set_i) |=> !req_o);

endmodule

// File: rtl/sysctl_regbank.sv
`timescale 1ns/1ps
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int NREGION = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_valid,
    input  logic                    acc_write,
    input  logic                    acc_user,
    input  logic [3:0]              acc_crn,
    input  logic [3:0]              acc_crm,
    input  logic [2:0]              acc_op1,
    input  logic [2:0]              acc_op2,
    input  logic [31:0]             acc_wdata,
    output logic [31:0]             acc_rdata,
    output logic                    acc_ok,
    input  logic                    irq_i,
    output logic                    endian_big_o,
    output logic                    vec_high_o,
    output logic                    pcload_interwork_o,
    output logic [31:0]             perm_data_o,
    output logic [31:0]             perm_inst_o,
    output logic [NREGION*32-1:0]   region_words_o,
    output logic [31:0]             dtcm_base_o,
    output logic [31:0]             itcm_base_o,
    output logic                    wfi_req_o
);

    cpsel_t          coord;
    hit_t            hit;
    logic            wr_en;
    logic [XLEN-1:0] reg_rd, ctrl_w, dtcm_w;

    assign coord = '{crn: acc_crn, crm: acc_crm, op1: acc_op1, op2: acc_op2};

    sysctl_decode #(.NREGION(NREGION)) u_decode (
        .a   (coord),
        .hit (hit)
    );

    always_comb begin
        acc_ok = acc_valid && !acc_user && (hit.sel != SEL_NONE);
        if (acc_write && sel_read_only(hit.sel))   acc_ok = 1'b0;
        if (!acc_write && sel_write_only(hit.sel)) acc_ok = 1'b0;
    end

    assign wr_en     = acc_ok && acc_write;
    assign acc_rdata = (acc_ok && !acc_write) ? reg_rd : '0;

    sysctl_regs #(.NREGION(NREGION)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .hit      (hit),
        .wdata    (acc_wdata),
        .rdata    (reg_rd),
        .ctrl_o   (ctrl_w),
        .perm_d_o (perm_data_o),
        .perm_i_o (perm_inst_o),
        .dtcm_o   (dtcm_w),
        .region_o (region_words_o)
    );

    sysctl_wfi u_wfi (
        .clk   (clk),
        .rst   (rst),
        .set_i (wr_en && hit.sel == SEL_WAIT),
        .irq_i (irq_i),
        .req_o (wfi_req_o)
    );

    assign endian_big_o       = ctrl_w[BIT_BIG_ENDIAN];
    assign vec_high_o         = ctrl_w[BIT_HIGH_VEC];
    assign pcload_interwork_o = !ctrl_w[BIT_NO_INTERWK];
    assign dtcm_base_o        = tcm_base(dtcm_w);
    assign itcm_base_o        = '0;

    p_user_reject_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_user) |-> !acc_ok && acc_rdata == '0);

    p_id_readonly_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_crn == 4'd0) |-> !acc_ok);

    p_dtcm_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && acc_write && acc_crn == 4'd9 && acc_crm == 4'd1 && acc_op2 == 3'd0)
        |=> dtcm_base_o == {$past(acc_wdata[31:6]), 6'd0});

    p_ok_valid_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !acc_ok);

endmodule

// File: tb/sysctl_regbank_bench.sv
`timescale 1ns/1ps
module sysctl_regbank_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_write, acc_user, irq_i;
    logic [3:0]  acc_crn, acc_crm;
    logic [2:0]  acc_op1, acc_op2;
    logic [31:0] acc_wdata, acc_rdata;
    logic        acc_ok;
    logic        endian_big_o, vec_high_o, pcload_interwork_o, wfi_req_o;
    logic [31:0] perm_data_o, perm_inst_o, dtcm_base_o, itcm_base_o;
    logic [255:0] region_words_o;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] m [0:20];

    always #2.5 clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_user(acc_user), .acc_crn(acc_crn), .acc_crm(acc_crm),
        .acc_op1(acc_op1), .acc_op2(acc_op2), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_ok(acc_ok), .irq_i(irq_i),
        .endian_big_o(endian_big_o), .vec_high_o(vec_high_o),
        .pcload_interwork_o(pcload_interwork_o), .perm_data_o(perm_data_o),
        .perm_inst_o(perm_inst_o), .region_words_o(region_words_o),
        .dtcm_base_o(dtcm_base_o), .itcm_base_o(itcm_base_o), .wfi_req_o(wfi_req_o)
    );

    task automatic chk(input bit good, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!good) begin
            n_fail++;
            if (n_fail < 40)
                $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // code: 0 id,1 ctype,2 tcmsz,3 ctrl,4 dcc,5 icc,6 wbuf,7 dperm,8 iperm,
    // 9..16 regions,17 dlock,18 ilock,19 dtcm,20 itcm,21 wait; -1 rejected
    function automatic int code_of(bit wr, int crn, int crm, int op1, int op2);
        int c = -1;
        if (crn == 0 && crm == 0 && op1 == 0) c = (op2 == 1) ? 1 : (op2 == 2) ? 2 : 0;
        if (crn == 1 && crm == 0 && op1 == 0 && op2 == 0) c = 3;
        if (crn == 2 && crm == 0 && op1 == 0 && op2 < 2) c = 4 + op2;
        if (crn == 3 && crm == 0 && op1 == 0 && op2 == 0) c = 6;
        if (crn == 5 && crm == 0 && op1 == 0 && (op2 == 2 || op2 == 3)) c = 5 + op2;
        if (crn == 6 && op1 == 0 && op2 == 0 && crm < 8) c = 9 + crm;
        if (crn == 7 && crm == 0 && op1 == 0 && op2 == 4) c = 21;
        if (crn == 9 && op1 == 0 && crm < 2 && op2 < 2) c = 17 + 2 * crm + op2;
        if (wr && c >= 0 && c <= 2) c = -1;
        if (!wr && c == 21) c = -1;
        return c;
    endfunction

    function automatic string req_of(int c);
        if (c < 0)             return "R9";
        if (c <= 2)            return "R2";
        if (c == 3)            return "R3";
        if (c == 7 || c == 8)  return "R5";
        if (c >= 9 && c <= 16) return "R6";
        if (c == 19 || c == 20) return "R7";
        return "R4";
    endfunction

    task automatic acc(input bit wr, input bit usr, input int crn, input int crm,
                       input int op1, input int op2, input logic [31:0] wd,
                       output bit ok, output logic [31:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_user = usr;
        acc_crn = 4'(crn); acc_crm = 4'(crm); acc_op1 = 3'(op1); acc_op2 = 3'(op2);
        acc_wdata = wd;
        #1;
        ok = acc_ok; rd = acc_rdata;
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    task automatic check_exports(input string tag);
        chk(endian_big_o == m[3][7], "R3", {tag, " endian"}, 32'(endian_big_o), 32'(m[3][7]));
        chk(vec_high_o == m[3][13], "R3", {tag, " vector"}, 32'(vec_high_o), 32'(m[3][13]));
        chk(pcload_interwork_o == !m[3][15], "R3", {tag, " interwork"},
            32'(pcload_interwork_o), 32'(!m[3][15]));
        chk(perm_data_o == m[7], "R5", {tag, " perm data"}, perm_data_o, m[7]);
        chk(perm_inst_o == m[8], "R5", {tag, " perm inst"}, perm_inst_o, m[8]);
        for (int k = 0; k < 8; k++)
            chk(region_words_o[k*32 +: 32] == m[9+k], "R6", {tag, " region"},
                region_words_o[k*32 +: 32], m[9+k]);
        chk(dtcm_base_o == (m[19] & 32'hFFFF_FFC0), "R7", {tag, " dtcm base"},
            dtcm_base_o, m[19] & 32'hFFFF_FFC0);
        chk(itcm_base_o == 32'h0, "R7", {tag, " itcm base"}, itcm_base_o, 32'h0);
    endtask

    task automatic read_sweep(input string tag);
        bit ok; logic [31:0] rd;
        for (int i = 0; i < 16384; i++) begin
            int c = code_of(0, i[13:10], i[9:6], i[5:3], i[2:0]);
            logic [31:0] e = (c >= 0) ? m[c] : 32'h0;
            acc(0, 0, i[13:10], i[9:6], i[5:3], i[2:0], 32'h0, ok, rd);
            chk(ok == (c >= 0) && rd == e, req_of(c), {tag, " read"}, rd, e);
        end
    endtask

    task automatic write_code(input int c, input logic [31:0] wd);
        bit ok; logic [31:0] rd;
        int crn, crm, op2;
        crm = 0; op2 = 0;
        if (c == 3) crn = 1;
        else if (c == 4 || c == 5) begin crn = 2; op2 = c - 4; end
        else if (c == 6) crn = 3;
        else if (c == 7 || c == 8) begin crn = 5; op2 = c - 5; end
        else if (c >= 9 && c <= 16) begin crn = 6; crm = c - 9; end
        else begin crn = 9; crm = (c - 17) / 2; op2 = (c - 17) % 2; end
        acc(1, 0, crn, crm, 0, op2, wd, ok, rd);
        chk(ok, req_of(c), "write accepted", 32'(ok), 32'h1);
        m[c] = wd;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit ok; logic [31:0] rd;
        rst = 1'b1; acc_valid = 0; acc_write = 0; acc_user = 0; irq_i = 0;
        acc_crn = 0; acc_crm = 0; acc_op1 = 0; acc_op2 = 0; acc_wdata = 0;
        m[0] = 32'h4104_9460; m[1] = 32'h0F0D_2112; m[2] = 32'h0014_0140;
        for (int k = 3; k <= 20; k++) m[k] = 32'h0;
        m[7] = 32'h2222_2222; m[8] = 32'h2222_2222;
        m[19] = 32'h0080_000A; m[20] = 32'h0000_000C;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        check_exports("reset");
        chk(wfi_req_o == 1'b0, "R8", "reset wait request", 32'(wfi_req_o), 32'h0);
        read_sweep("reset");

        // R1: user-mode reads and writes over every coordinate
        for (int i = 0; i < 16384; i++) begin
            bit w = i[0];
            acc(w, 1, i[13:10], i[9:6], i[5:3], i[2:0], 32'hFFFF_FFFF, ok, rd);
            chk(!ok && rd == 32'h0, "R1", "user access", rd, 32'h0);
            acc(!w, 1, i[13:10], i[9:6], i[5:3], i[2:0], 32'hFFFF_FFFF, ok, rd);
            chk(!ok && rd == 32'h0, "R1", "user access", rd, 32'h0);
        end
        chk(wfi_req_o == 1'b0, "R1", "user wait write ignored", 32'(wfi_req_o), 32'h0);

        // R9/R2: privileged writes to every rejected encoding
        for (int i = 0; i < 16384; i++) begin
            if (code_of(1, i[13:10], i[9:6], i[5:3], i[2:0]) < 0) begin
                acc(1, 0, i[13:10], i[9:6], i[5:3], i[2:0], 32'hFFFF_FFFF, ok, rd);
                chk(!ok, (i[13:10] == 0) ? "R2" : "R9", "rejected write", 32'(ok), 32'h0);
            end
        end
        check_exports("after rejects");
        read_sweep("after rejects");

        // R10: no access strobe, nothing changes
        @(negedge clk);
        acc_write = 1; acc_user = 0; acc_crn = 1; acc_crm = 0; acc_op1 = 0; acc_op2 = 0;
        acc_wdata = 32'hFFFF_FFFF;
        #1 chk(acc_ok == 1'b0, "R10", "ok without valid", 32'(acc_ok), 32'h0);
        @(posedge clk); #1;
        check_exports("R10 idle");

        // R3: control bit combinations
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v = (32'(k & 1) << 7) | (32'((k >> 1) & 1) << 13) |
                             (32'((k >> 2) & 1) << 15);
            write_code(3, v);
            check_exports("R3 control");
        end

        // R5: permission word visible only after the edge
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_user = 0;
        acc_crn = 5; acc_crm = 0; acc_op1 = 0; acc_op2 = 2; acc_wdata = 32'h1357_9BDF;
        #1 chk(perm_data_o == m[7], "R5", "before edge", perm_data_o, m[7]);
        @(posedge clk); #1 acc_valid = 0;
        m[7] = 32'h1357_9BDF;
        chk(perm_data_o == m[7], "R5", "after edge", perm_data_o, m[7]);

        // R4..R7: distinct patterns into every writable word
        for (int c = 3; c <= 20; c++)
            write_code(c, 32'h5A3C_0F00 ^ (32'(c) * 32'h0101_0101));
        write_code(19, 32'h1234_567F);
        write_code(20, 32'hFFFF_FFFF);
        check_exports("patterns");
        read_sweep("patterns");

        // R8: wait-for-interrupt
        acc(1, 0, 7, 0, 0, 4, 32'h0, ok, rd);
        chk(ok, "R8", "wait write accepted", 32'(ok), 32'h1);
        chk(wfi_req_o == 1'b1, "R8", "wait raised", 32'(wfi_req_o), 32'h1);
        repeat (5) @(posedge clk);
        #1 chk(wfi_req_o == 1'b1, "R8", "wait held", 32'(wfi_req_o), 32'h1);
        @(negedge clk) irq_i = 1;
        @(posedge clk); #1 irq_i = 0;
        chk(wfi_req_o == 1'b0, "R8", "wait cleared", 32'(wfi_req_o), 32'h0);
        @(posedge clk); #1;
        chk(wfi_req_o == 1'b0, "R8", "wait stays low", 32'(wfi_req_o), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule